// File: doc/BRIEF.md
# Reconfigurable Region Isolation Controller

This block walks one reconfigurable region of a chip through a logic swap. While the region is idle it is fully transparent. Its data and valid signals reach the static logic unchanged, and the handshakes of its input and output channels pass straight through.

When a swap is requested, the controller runs a fixed sequence:

1. It fences the region off. Every signal leaving the region is forced to zero.
2. After one fenced cycle it strobes the external configuration loader.
3. It waits, for as long as needed, until the loader reports completion.
4. It holds the region's reset for a programmable number of cycles, so the new logic starts from a known state.
5. It keeps the fence up for one further cycle, then drops it.

Throughout the swap, the producer feeding the region and the consumer fed by it both see a stalled channel. Each region gets its own instance of the controller, and every non-clock signal between the region and static logic is routed through it.

Top module: `rr_iso_ctrl`

## Requirements
- R1: After reset `busy_o`, `load_start_o` and `rgn_rst_o` are 0 and the block is transparent.
- R2: While not busy, `st_data_o` equals `rgn_data_i`, `st_vld_o` equals `rgn_vld_i`, `up_rdy_o` equals `rgn_in_rdy_i` and `rgn_in_vld_o` equals `up_vld_i`.
- R3: A `swap_req_i` sampled while idle makes `busy_o` 1 from the next cycle. From that cycle on, `st_data_o` is all zeros and `st_vld_o` is 0.
- R4: `load_start_o` is a single-cycle pulse. It rises exactly one cycle after the first fenced cycle, and it is never 1 unless the outputs were already fenced in the previous cycle.
- R5: After the pulse, the block waits indefinitely for `load_done_i`. During the wait `rgn_rst_o` stays 0 and the fence stays up.
- R6: `rgn_rst_o` is 1 for exactly RST_CYCLES cycles (default 4). It starts in the cycle after `load_done_i` is sampled during the wait.
- R7: After `rgn_rst_o` falls, the outputs stay fenced and `busy_o` stays 1 for exactly one cycle. In the following cycle the block is idle and transparent again.
- R8: While `busy_o` is 1, `up_rdy_o`, `rgn_in_vld_o` and `st_vld_o` are all 0, whatever the channel inputs are.
- R9: A `swap_req_i` that arrives while busy is ignored. It neither restarts nor lengthens the sequence, and it produces no second load pulse.
- R10: A `load_done_i` that arrives outside the wait phase is ignored. It neither pulses the reset nor makes the block busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| swap_req_i | input | 1 | Request to start a swap |
| load_done_i | input | 1 | Loader reports completion |
| load_start_o | output | 1 | One-cycle strobe to the loader |
| busy_o | output | 1 | Swap in progress |
| rgn_rst_o | output | 1 | Active-high reset to the region |
| rgn_data_i | input | DATA_W | Data leaving the region |
| rgn_vld_i | input | 1 | Valid leaving the region |
| st_data_o | output | DATA_W | Fenced data to static logic |
| st_vld_o | output | 1 | Fenced valid to the downstream consumer |
| up_vld_i | input | 1 | Upstream producer valid |
| rgn_in_vld_o | output | 1 | Valid presented to the region |
| rgn_in_rdy_i | input | 1 | Region ready for input |
| up_rdy_o | output | 1 | Ready returned to the upstream producer |

## Verification
The assertions check the following on every cycle:
- the fenced outputs and stalled handshakes while busy;
- that the load strobe follows a fenced cycle and lasts one cycle;
- that reset starts only after a completion;
- that reset ends into a fenced cycle.

Other properties need whole sequences and can only be shown by the bench scenarios:
- the exact reset length;
- the unbounded wait for the loader;
- that requests and completions arriving at the wrong moment are ignored;
- the return to transparency.

The bench therefore runs swaps with random loader delays, random data, and stray requests injected during the swap.

// File: rtl/rr_iso_pkg.sv
package rr_iso_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ISOLATE = 3'd1,
        ST_LOAD    = 3'd2,
        ST_RESET   = 3'd3,
        ST_RELEASE = 3'd4
    } rr_state_e;
endpackage

// File: rtl/rr_seq_fsm.sv
module rr_seq_fsm
    import rr_iso_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic swap_req_i,
    input  logic load_done_i,
    output logic load_start_o,
    output logic rgn_rst_o,
    output logic fence_o
);
    localparam int CNT_W = (RST_CYCLES < 2) ? 1 : $clog2(RST_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_CYCLES - 1);

    typedef struct packed {
        rr_state_e        state;
        logic [CNT_W-1:0] cnt;
        logic             ld_start;
        logic             rst;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d          = r_q;
        r_d.ld_start = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (swap_req_i) r_d.state = ST_ISOLATE;
            end
            ST_ISOLATE: begin
                r_d.state    = ST_LOAD;
                r_d.ld_start = 1'b1;
            end
            ST_LOAD: begin
                if (load_done_i) begin
                    r_d.state = ST_RESET;
                    r_d.rst   = 1'b1;
                    r_d.cnt   = '0;
                end
            end
            ST_RESET: begin
                if (r_q.cnt == CNT_LAST) begin
                    r_d.state = ST_RELEASE;
                    r_d.rst   = 1'b0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_RELEASE: begin
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, cnt: '0, ld_start: 1'b0, rst: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign load_start_o = r_q.ld_start;
    assign rgn_rst_o    = r_q.rst;
    assign fence_o      = (r_q.state != ST_IDLE);

    // R4
    ld_after_fence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_start_o |-> $past(fence_o));
    // R4
    ld_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_start_o |=> !load_start_o);
    // R6
    rst_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rgn_rst_o) |-> $past(load_done_i));
    // R7
    rst_end_fenced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rgn_rst_o) |-> (fence_o && r_q.state == ST_RELEASE));
    // R5
    no_rst_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_LOAD) |-> !rgn_rst_o);
endmodule

// File: rtl/rr_boundary_gate.sv
module rr_boundary_gate #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fence_i,
    input  logic [DATA_W-1:0] rgn_data_i,
    input  logic              rgn_vld_i,
    output logic [DATA_W-1:0] st_data_o,
    output logic              st_vld_o,
    input  logic              up_vld_i,
    output logic              rgn_in_vld_o,
    input  logic              rgn_in_rdy_i,
    output logic              up_rdy_o
);
    for (genvar b = 0; b < DATA_W; b++) begin : g_lane
        assign st_data_o[b] = rgn_data_i[b] & ~fence_i;
    end

    assign st_vld_o     = rgn_vld_i & ~fence_i;
    assign rgn_in_vld_o = up_vld_i & ~fence_i;
    assign up_rdy_o     = rgn_in_rdy_i & ~fence_i;

    // R3
    data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fence_i |-> (st_data_o == '0));
    // R8
    chan_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fence_i |-> !(st_vld_o || rgn_in_vld_o || up_rdy_o));
endmodule

// File: rtl/rr_iso_ctrl.sv
module rr_iso_ctrl #(
    parameter int DATA_W     = 8,
    parameter int RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              swap_req_i,
    input  logic              load_done_i,
    output logic              load_start_o,
    output logic              busy_o,
    output logic              rgn_rst_o,
    input  logic [DATA_W-1:0] rgn_data_i,
    input  logic              rgn_vld_i,
    output logic [DATA_W-1:0] st_data_o,
    output logic              st_vld_o,
    input  logic              up_vld_i,
    output logic              rgn_in_vld_o,
    input  logic              rgn_in_rdy_i,
    output logic              up_rdy_o
);
    logic fence;

    rr_seq_fsm #(.RST_CYCLES(RST_CYCLES)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .swap_req_i   (swap_req_i),
        .load_done_i  (load_done_i),
        .load_start_o (load_start_o),
        .rgn_rst_o    (rgn_rst_o),
        .fence_o      (fence)
    );

    rr_boundary_gate #(.DATA_W(DATA_W)) u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .fence_i      (fence),
        .rgn_data_i   (rgn_data_i),
        .rgn_vld_i    (rgn_vld_i),
        .st_data_o    (st_data_o),
        .st_vld_o     (st_vld_o),
        .up_vld_i     (up_vld_i),
        .rgn_in_vld_o (rgn_in_vld_o),
        .rgn_in_rdy_i (rgn_in_rdy_i),
        .up_rdy_o     (up_rdy_o)
    );

    assign busy_o = fence;
endmodule

// File: tb/rr_iso_ctrl_tb.sv
`timescale 1ns/1ps
module rr_iso_ctrl_tb_top;
    localparam int DW  = 8;
    localparam int RST = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic swap_req = 1'b0, load_done = 1'b0;
    logic load_start, busy, rgn_rst;
    logic [DW-1:0] rgn_data = '0, st_data;
    logic rgn_vld = 1'b0, st_vld, up_vld = 1'b0, rgn_in_vld, rgn_in_rdy = 1'b0, up_rdy;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rr_iso_ctrl #(.DATA_W(DW), .RST_CYCLES(RST)) dut_i (
        .clk(clk), .rst_n(rst_n), .swap_req_i(swap_req), .load_done_i(load_done),
        .load_start_o(load_start), .busy_o(busy), .rgn_rst_o(rgn_rst),
        .rgn_data_i(rgn_data), .rgn_vld_i(rgn_vld), .st_data_o(st_data), .st_vld_o(st_vld),
        .up_vld_i(up_vld), .rgn_in_vld_o(rgn_in_vld), .rgn_in_rdy_i(rgn_in_rdy), .up_rdy_o(up_rdy)
    );

    function automatic logic [DW+2:0] exp_bound(logic fenced);
        if (fenced) return '0;
        return {rgn_data, rgn_vld, up_vld, rgn_in_rdy};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic rand_inputs();
        rgn_data   = DW'($urandom);
        rgn_vld    = 1'($urandom);
        up_vld     = 1'($urandom);
        rgn_in_rdy = 1'($urandom);
    endtask

    task automatic chk_bound(string req, logic fenced);
        chk(req, 32'({st_data, st_vld, rgn_in_vld, up_rdy}), 32'(exp_bound(fenced)));
    endtask

    task automatic chk_ctl(string req, logic eb, logic el, logic er);
        chk({req, " busy"}, 32'(busy), 32'(eb));
        chk({req, " load_start"}, 32'(load_start), 32'(el));
        chk({req, " rgn_rst"}, 32'(rgn_rst), 32'(er));
    endtask

    // One full swap; inputs driven and outputs sampled at negedges
    task automatic do_swap(int ld_delay, bit poke);
        @(negedge clk); swap_req = 1'b1; rand_inputs();
        @(negedge clk); swap_req = poke; rgn_vld = 1'b1; up_vld = 1'b1; rgn_in_rdy = 1'b1;
        rgn_data = '1;
        // ISOLATE
        chk_ctl("R3 isolate", 1'b1, 1'b0, 1'b0);
        chk_bound("R3 R8 isolate fence", 1'b1);
        @(negedge clk); swap_req = 1'b0;
        // LOAD, first cycle
        chk_ctl("R4 strobe", 1'b1, 1'b1, 1'b0);
        chk_bound("R8 load fence", 1'b1);
        for (int i = 0; i < ld_delay; i++) begin
            swap_req = poke ? 1'($urandom) : 1'b0;
            rand_inputs();
            @(negedge clk);
            chk_ctl("R5 R9 wait", 1'b1, 1'b0, 1'b0);
            chk_bound("R8 wait fence", 1'b1);
        end
        load_done = 1'b1; swap_req = poke;
        @(negedge clk); load_done = 1'b0;
        for (int i = 0; i < RST; i++) begin
            rand_inputs();
            chk_ctl("R6 reset pulse", 1'b1, 1'b0, 1'b1);
            chk_bound("R8 reset fence", 1'b1);
            @(negedge clk);
        end
        swap_req = 1'b0;
        // RELEASE
        chk_ctl("R7 release", 1'b1, 1'b0, 1'b0);
        chk_bound("R7 release fence", 1'b1);
        @(negedge clk);
        rand_inputs();
        #1;
        chk_ctl("R7 back idle", 1'b0, 1'b0, 1'b0);
        chk_bound("R2 transparent after swap", 1'b0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rand_inputs();
        #1;
        chk_ctl("R1 reset state", 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_ctl("R1 after reset", 1'b0, 1'b0, 1'b0);
        // R2 random pass-through
        for (int i = 0; i < 20; i++) begin
            rand_inputs();
            #1;
            chk_bound("R2 idle transparent", 1'b0);
            @(negedge clk);
            chk_ctl("R2 stays idle", 1'b0, 1'b0, 1'b0);
        end
        // R10 stray completion while idle
        load_done = 1'b1;
        @(negedge clk); load_done = 1'b0;
        chk_ctl("R10 stray done", 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk_ctl("R10 stray done later", 1'b0, 1'b0, 1'b0);
        // Directed corners
        do_swap(0, 1'b0);
        do_swap(1, 1'b1);
        do_swap(37, 1'b1);
        // Random swaps
        for (int n = 0; n < 25; n++) begin
            do_swap(int'($urandom_range(0, 12)), 1'($urandom));
            repeat (int'($urandom_range(0, 3))) begin
                @(negedge clk); rand_inputs(); #1;
                chk_bound("R2 idle between swaps", 1'b0);
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule